// File: doc/BRIEF.md
# Fixed Off-Time Winding Chopper

This block is the digital half of a peak-current regulator for a single H-bridge motor winding. It turns a synchronised "current has reached its limit" flag into gate enables for the four switches of the bridge. While the winding charges, one diagonal pair conducts. When the limit is reached, the bridge spends a programmed number of clock cycles decaying the current, and then conducts again. The decay can be slow (recirculation on one low-side switch), fast (the opposite diagonal pair is driven) or mixed (fast for a programmed number of cycles, then slow).

The trip flag is masked for a programmed blanking window each time the bridge starts conducting: after every decay interval, after a change of direction and after the bridge is re-enabled. Reversing the direction inserts a programmed dead interval with every switch off. A zero current code or a thermal fault forces every switch off. All intervals are counted in system clock cycles from configuration inputs, which are registered inside the block. The analog comparator, the threshold DAC, the gate drivers and the temperature sensing lie outside the block.

Top module: `chopper_ctrl`

## Requirements
- R1: While the bridge conducts, exactly one diagonal pair is on. With `dir_in`=1 this is `hs_a` with `ls_b`; with `dir_in`=0 it is `hs_b` with `ls_a`.
- R2: `trip_in` passes through a two-stage synchroniser. If it is raised while the bridge conducts outside blanking, a decay interval follows on the third rising edge. The decay interval lasts max(`off_len_in`,1) cycles.
- R3: `decay_sel`=0 selects slow decay. For the whole decay interval, only the low-side switch of the conducting pair stays on (`ls_b` when `dir_in`=1, `ls_a` when `dir_in`=0).
- R4: `decay_sel`=1 selects fast decay. For the whole decay interval, the opposite diagonal pair is on.
- R5: `decay_sel`=2 or 3 selects mixed decay. The first min(`fast_len_in`, max(`off_len_in`,1)) cycles of the decay interval drive the opposite pair, and the remaining cycles drive the slow pattern of R3.
- R6: When a decay interval ends, the conducting pair is enabled again at once. `trip_in` is ignored for max(`blank_len_in`,1) cycles, during which the pair stays on.
- R7: A change of `dir_in` while enabled turns every switch off on the next edge. The switches stay off for max(`dead_len_in`,1) cycles, and then the new pair conducts, starting with a blanking window.
- R8: `level_in`=000 turns all four switches off on the next edge. A nonzero code re-enables the bridge on the next edge with a blanking window, during which `trip_in` is ignored.
- R9: `therm_fault`=1 turns all four switches off on the next edge, and they stay off while it is held. When it clears, the bridge resumes through blanking.
- R10: A synchronous `rst` puts the block in the disabled state with all four switches off.
- R11: `hs_a` and `ls_a` are never on together, and `hs_b` and `ls_b` are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| trip_in | input | 1 | Current limit flag, asynchronous to clk |
| dir_in | input | 1 | Winding current direction |
| level_in | input | 3 | Current code; 000 disables the bridge |
| decay_sel | input | 2 | 0 slow, 1 fast, 2 or 3 mixed |
| fast_len_in | input | CW | Fast portion of a mixed decay, in cycles |
| off_len_in | input | CW | Decay interval, in cycles |
| blank_len_in | input | CW | Trip blanking window, in cycles |
| dead_len_in | input | CW | Dead interval on reversal, in cycles |
| therm_fault | input | 1 | Over-temperature flag |
| hs_a | output | 1 | High-side switch, leg A |
| ls_a | output | 1 | Low-side switch, leg A |
| hs_b | output | 1 | High-side switch, leg B |
| ls_b | output | 1 | Low-side switch, leg B |

## Verification
Gate outputs decode the state register, so a direction, code or fault change shows on the outputs one edge after it is applied. A trip shows three edges after it is applied: two synchroniser stages and then the state register. The configuration counts are registered as well, so the bench changes them only while the bridge is disabled and waits a few cycles before enabling it. The bench drives inputs and samples outputs on the falling edge. It counts the rising edges from each stimulus to find the first sample, then checks every cycle of each decay, dead and blanking interval against the pattern expected for that cycle.

// File: rtl/chop_pkg.sv
`timescale 1ns/1ps
package chop_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DEAD  = 3'd1,
    ST_BLANK = 3'd2,
    ST_ON    = 3'd3,
    ST_DECAY = 3'd4
  } chop_st_e;

  localparam logic [1:0] DM_SLOW = 2'd0;
  localparam logic [1:0] DM_FAST = 2'd1;
endpackage

// File: rtl/chop_sync.sv
`timescale 1ns/1ps
module chop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/chop_timer.sv
`timescale 1ns/1ps
module chop_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] rem,
  output logic          last
);
  always_ff @(posedge clk) begin
    if (rst)                rem <= '0;
    else if (load)          rem <= load_val;
    else if (rem > CW'(1))  rem <= rem - CW'(1);
  end

  assign last = (rem < CW'(2));
endmodule

// File: rtl/chop_gates.sv
`timescale 1ns/1ps
module chop_gates
  import chop_pkg::*;
(
  input  chop_st_e   st,
  input  logic       dir,
  input  logic       fast_ph,
  output logic [3:0] g
);
  logic [3:0] drive_pair, reverse_pair, slow_pat;

  always_comb begin
    drive_pair   = dir ? 4'b1001 : 4'b0110;
    reverse_pair = dir ? 4'b0110 : 4'b1001;
    slow_pat     = dir ? 4'b0001 : 4'b0100;
    unique case (st)
      ST_BLANK, ST_ON: g = drive_pair;
      ST_DECAY:        g = fast_ph ? reverse_pair : slow_pat;
      default:         g = 4'b0000;
    endcase
  end
endmodule

// File: rtl/chopper_ctrl.sv
`timescale 1ns/1ps
module chopper_ctrl
  import chop_pkg::*;
#(
  parameter int CW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          trip_in,
  input  logic          dir_in,
  input  logic [2:0]    level_in,
  input  logic [1:0]    decay_sel,
  input  logic [CW-1:0] fast_len_in,
  input  logic [CW-1:0] off_len_in,
  input  logic [CW-1:0] blank_len_in,
  input  logic [CW-1:0] dead_len_in,
  input  logic          therm_fault,
  output logic          hs_a,
  output logic          ls_a,
  output logic          hs_b,
  output logic          ls_b
);
  function automatic logic [CW-1:0] at_least_one(input logic [CW-1:0] v);
    return (v == '0) ? CW'(1) : v;
  endfunction

  function automatic logic [CW-1:0] fast_portion(input logic [1:0] mode,
                                                 input logic [CW-1:0] f,
                                                 input logic [CW-1:0] o_eff);
    if (mode == DM_SLOW)      return '0;
    else if (mode == DM_FAST) return o_eff;
    else                      return (f > o_eff) ? o_eff : f;
  endfunction

  // registered configuration
  logic [1:0]    cfg_mode;
  logic [CW-1:0] cfg_fast, cfg_off, cfg_blank, cfg_dead;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_mode  <= DM_SLOW;
      cfg_fast  <= '0;
      cfg_off   <= '0;
      cfg_blank <= '0;
      cfg_dead  <= '0;
    end else begin
      cfg_mode  <= decay_sel;
      cfg_fast  <= fast_len_in;
      cfg_off   <= off_len_in;
      cfg_blank <= blank_len_in;
      cfg_dead  <= dead_len_in;
    end
  end

  // named internal events
  logic          trip_s;
  logic          run_ok;
  logic          dir_flip;
  logic          dir_q;
  chop_st_e      st, st_n;
  logic          t_load;
  logic [CW-1:0] t_val, t_rem;
  logic          t_last;
  logic [CW-1:0] off_eff, elapsed;
  logic          fast_ph;
  logic [3:0]    gates;

  chop_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(trip_in), .q(trip_s)
  );

  chop_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val),
    .rem(t_rem), .last(t_last)
  );

  assign run_ok   = (level_in != 3'b000) && !therm_fault;
  assign dir_flip = (dir_in != dir_q);

  always_comb begin
    st_n   = st;
    t_load = 1'b0;
    t_val  = '0;
    if (!run_ok) begin
      st_n = ST_IDLE;
    end else if (st == ST_IDLE) begin
      st_n   = ST_BLANK;
      t_load = 1'b1;
      t_val  = at_least_one(cfg_blank);
    end else if (dir_flip) begin
      st_n   = ST_DEAD;
      t_load = 1'b1;
      t_val  = at_least_one(cfg_dead);
    end else begin
      unique case (st)
        ST_DEAD: if (t_last) begin
          st_n   = ST_BLANK;
          t_load = 1'b1;
          t_val  = at_least_one(cfg_blank);
        end
        ST_BLANK: if (t_last) st_n = ST_ON;
        ST_ON: if (trip_s) begin
          st_n   = ST_DECAY;
          t_load = 1'b1;
          t_val  = at_least_one(cfg_off);
        end
        ST_DECAY: if (t_last) begin
          st_n   = ST_BLANK;
          t_load = 1'b1;
          t_val  = at_least_one(cfg_blank);
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      dir_q <= 1'b0;
    end else begin
      st <= st_n;
      if (st == ST_IDLE || dir_flip) dir_q <= dir_in;
    end
  end

  assign off_eff = at_least_one(cfg_off);
  assign elapsed = off_eff - t_rem;
  assign fast_ph = (st == ST_DECAY) &&
                   (elapsed < fast_portion(cfg_mode, cfg_fast, off_eff));

  chop_gates u_gates (.st(st), .dir(dir_q), .fast_ph(fast_ph), .g(gates));

  assign {hs_a, ls_a, hs_b, ls_b} = gates;
endmodule

// File: rtl/chop_chk.sv
`timescale 1ns/1ps
module chop_chk
  import chop_pkg::*;
(
  input logic     clk,
  input logic     rst,
  input chop_st_e st,
  input logic     dir_q,
  input logic     trip_s,
  input logic     run_ok,
  input logic     dir_flip,
  input logic [2:0] level_in,
  input logic     therm_fault,
  input logic     hs_a,
  input logic     ls_a,
  input logic     hs_b,
  input logic     ls_b
);
  logic [3:0] g;
  assign g = {hs_a, ls_a, hs_b, ls_b};

  p_on_pair_r1: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ON) |-> ($countones(g) == 2 && hs_a == dir_q && ls_b == dir_q));

  p_trip_to_decay_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ON && trip_s && run_ok && !dir_flip) |=> (st == ST_DECAY));

  p_blank_masks_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BLANK) |=> (st != ST_DECAY));

  p_dead_after_flip_r7: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_BLANK || st == ST_ON || st == ST_DECAY) && run_ok && dir_flip)
      |=> (g == 4'b0000));

  p_zero_code_off_r8: assert property (@(posedge clk) disable iff (rst)
    (level_in == 3'b000) |=> (g == 4'b0000));

  p_fault_off_r9: assert property (@(posedge clk) disable iff (rst)
    therm_fault |=> (g == 4'b0000));

  p_reset_idle_r10: assert property (@(posedge clk)
    rst |=> (st == ST_IDLE));

  p_leg_exclusive_r11: assert property (@(posedge clk) disable iff (rst)
    !(hs_a && ls_a) && !(hs_b && ls_b));
endmodule

bind chopper_ctrl chop_chk u_chk (
  .clk(clk), .rst(rst), .st(st), .dir_q(dir_q), .trip_s(trip_s),
  .run_ok(run_ok), .dir_flip(dir_flip), .level_in(level_in),
  .therm_fault(therm_fault), .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b)
);

// File: tb/sim_chopper_ctrl.sv
`timescale 1ns/1ps
module sim_chopper_ctrl;
  localparam int CW = 8;
  localparam int NV = 7;
  // {mode[18:17], fast[16:9], off[8:1], dir[0]}
  localparam logic [18:0] VEC [NV] = '{
    {2'd0, 8'd0, 8'd5, 1'b1},
    {2'd1, 8'd0, 8'd4, 1'b0},
    {2'd2, 8'd2, 8'd6, 1'b1},
    {2'd2, 8'd9, 8'd3, 1'b0},
    {2'd3, 8'd0, 8'd4, 1'b1},
    {2'd1, 8'd0, 8'd0, 1'b1},
    {2'd2, 8'd3, 8'd3, 1'b0}
  };

  logic clk = 1'b0;
  logic rst, trip, dir, therm;
  logic [2:0] level;
  logic [1:0] mode;
  logic [CW-1:0] fastc, offc, blankc, deadc;
  logic hs_a, ls_a, hs_b, ls_b;
  logic [3:0] g;
  int n_chk = 0, n_err = 0;
  logic leg_bad = 1'b0;

  always #2.5 clk = ~clk;

  chopper_ctrl #(.CW(CW)) u0 (
    .clk(clk), .rst(rst), .trip_in(trip), .dir_in(dir), .level_in(level),
    .decay_sel(mode), .fast_len_in(fastc), .off_len_in(offc),
    .blank_len_in(blankc), .dead_len_in(deadc), .therm_fault(therm),
    .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b)
  );

  assign g = {hs_a, ls_a, hs_b, ls_b};

  always @(negedge clk) if (!rst && ((hs_a && ls_a) || (hs_b && ls_b))) leg_bad <= 1'b1;

  function automatic logic [3:0] pair(input logic d);
    return d ? 4'b1001 : 4'b0110;
  endfunction

  function automatic logic [3:0] off_pat(input logic [1:0] m, input int f,
                                         input int o, input logic d, input int k);
    int ol, fl;
    ol = (o == 0) ? 1 : o;
    if (m == 2'd0)      fl = 0;
    else if (m == 2'd1) fl = ol;
    else                fl = (f < ol) ? f : ol;
    if (k < fl) return d ? 4'b0110 : 4'b1001;
    return d ? 4'b0001 : 4'b0100;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [3:0] exp);
    n_chk++;
    if (g !== exp) begin
      n_err++;
      $display("FAIL %s: gates=%b expected %b at %0t", req, g, exp, $time);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    rst = 1'b1; trip = 1'b0; dir = 1'b1; therm = 1'b0; level = 3'b000;
    mode = 2'd0; fastc = '0; offc = 8'd4; blankc = 8'd2; deadc = 8'd3;
    cyc(3);
    chk("R10 reset", 4'b0000);
    rst = 1'b0;
    cyc(2);

    // table walk: one decay interval per vector
    for (int i = 0; i < NV; i++) begin
      logic [1:0] vm; logic [7:0] vf, vo; logic vd; int ol;
      string rq;
      {vm, vf, vo, vd} = VEC[i];
      ol = (vo == 0) ? 1 : int'(vo);
      rq = (vm == 2'd0) ? "R3 slow" : (vm == 2'd1) ? "R4 fast" : "R5 mixed";
      level = 3'b000; mode = vm; fastc = vf; offc = vo; dir = vd; blankc = 8'd2;
      cyc(3);
      level = 3'b101;
      cyc(3);                       // BLANK for 2 cycles, then ON
      chk("R1 pair", pair(vd));
      trip = 1'b1;
      cyc(3);                       // two sync stages plus state edge
      trip = 1'b0;
      for (int k = 0; k < ol; k++) begin
        chk(k == 0 ? "R2 trip" : rq, off_pat(vm, vf, vo, vd, k));
        cyc(1);
      end
      chk("R6 reenable", pair(vd));
    end

    // blanking masks a trip raised right after enable
    level = 3'b000; mode = 2'd0; offc = 8'd3; blankc = 8'd8; dir = 1'b1;
    cyc(3);
    level = 3'b111;
    cyc(1);
    trip = 1'b1;
    for (int k = 0; k < 8; k++) begin
      chk("R6 blank", 4'b1001);
      cyc(1);
    end
    chk("R6 on after blank", 4'b1001);
    cyc(1);
    chk("R2 trip after blank", 4'b0001);
    trip = 1'b0;

    // direction change: dead interval then new pair
    deadc = 8'd4;
    cyc(20);
    chk("R1 pair before reversal", 4'b1001);
    dir = 1'b0;
    for (int k = 0; k < 4; k++) begin
      cyc(1);
      chk("R7 dead", 4'b0000);
    end
    cyc(1);
    chk("R7 new pair", 4'b0110);

    // zero code disables; re-enable with blanking
    blankc = 8'd6;
    cyc(10);
    level = 3'b000;
    cyc(1);
    chk("R8 zero code", 4'b0000);
    cyc(2);
    chk("R8 held off", 4'b0000);
    level = 3'b011; trip = 1'b1;
    cyc(1);
    chk("R8 reenable", 4'b0110);
    cyc(3);
    chk("R8 trip ignored in blank", 4'b0110);
    trip = 1'b0;

    // thermal fault
    cyc(10);
    therm = 1'b1;
    cyc(1);
    chk("R9 fault off", 4'b0000);
    cyc(5);
    chk("R9 fault held", 4'b0000);
    therm = 1'b0;
    cyc(1);
    chk("R9 resume", 4'b0110);

    // reset while running
    cyc(5);
    rst = 1'b1;
    cyc(1);
    chk("R10 reset midrun", 4'b0000);
    rst = 1'b0;
    cyc(2);

    n_chk++;
    if (leg_bad) begin
      n_err++;
      $display("FAIL R11 leg: shoot-through seen=1 expected 0");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule